// File: doc/BRIEF.md
# Cascadable Four-Bit ALU Word

This block is a word-wide arithmetic logic unit assembled from identical four-bit slices. Each slice combines two four-bit operand nibbles, a carry input and a three-bit function code into a four-bit result, a carry output and a two's-complement overflow flag. Slices are chained so that each carry output drives the carry input of the next more significant slice. The word result, the carry out of the top slice and the overflow flag of the top slice form the word outputs.

Eight function codes cover several kinds of operation. Three are arithmetic: a sum and a difference in each direction. Three are bitwise: exclusive-OR, inclusive-OR and AND. Two force constants: an all-zero word and an all-one word. A difference is formed as one operand plus the complement of the other plus the carry input. A true difference therefore needs the carry input held at 1, and with it at 0 the result is one lower. The word outputs are registered once, with a synchronous active-high reset, so a result appears one clock after its inputs are sampled.

Top module: `ripple_alu`

## Requirements
- R1: Function code 3'b000 (func[0] is the least significant bit) gives result = 0, carry_out = 1 and ovf = 1 whatever op_a, op_b and carry_in are.
- R2: Function code 3'b111 gives result = all ones, carry_out = 0 and ovf = 0.
- R3: Function code 3'b011 gives result = (op_a + op_b + carry_in) mod 2^WIDTH, and carry_out is bit WIDTH of that sum.
- R4: Function code 3'b001 gives op_b + ~op_a + carry_in. With carry_in = 1 the result is op_b - op_a, and with carry_in = 0 it is op_b - op_a - 1. carry_out is bit WIDTH of the sum.
- R5: Function code 3'b010 gives op_a + ~op_b + carry_in, with result and carry_out formed as in R4.
- R6: In the three arithmetic codes, ovf equals the carry into the most significant bit XOR the carry out of it. This is the signed overflow of the word operation.
- R7: Function codes 3'b100, 3'b101 and 3'b110 give op_a XOR op_b, op_a OR op_b and op_a AND op_b. In these codes the result does not depend on carry_in, and carry_out = ovf = 0.
- R8: Outputs change only at a rising clock edge and reflect the inputs sampled there. A high rst at an edge sets result, carry_out and ovf to 0.
- R9: WIDTH is a multiple of 4. Slice carries ripple upward and the word result matches full-width arithmetic. Adding 1111 + 1111 on a four-bit word gives 1110 with carry_in = 0 and 1111 with carry_in = 1, each time with carry_out = 1 and ovf = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into the least significant slice |
| func | input | 3 | Function code |
| result | output | WIDTH | Registered result word |
| carry_out | output | 1 | Registered carry out of the top slice |
| ovf | output | 1 | Registered two's-complement overflow of the top slice |

## Verification
The slice chain has no state, so every result, carry and overflow value is due at the first rising edge after its inputs are driven. A reset is due at that same edge. Inputs change on the falling edge, and the expected values for that stimulus are queued at that moment. A monitor removes one entry shortly after each rising edge and compares it with the registered outputs, so each entry meets exactly the edge that captured its stimulus. A four-bit and a sixteen-bit instance are driven together, which exercises both a lone slice and a four-slice ripple.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;

  localparam int SLICE_W = 4;

  typedef enum logic [2:0] {
    FN_ZERO    = 3'b000,
    FN_B_SUB_A = 3'b001,
    FN_A_SUB_B = 3'b010,
    FN_ADD     = 3'b011,
    FN_XOR     = 3'b100,
    FN_OR      = 3'b101,
    FN_AND     = 3'b110,
    FN_ONES    = 3'b111
  } alu_fn_e;

endpackage

// File: rtl/alu_slice4.sv
module alu_slice4
  import ripple_alu_pkg::*;
#(
  parameter int SW = SLICE_W
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          cin,
  input  logic [2:0]    fn,
  output logic [SW-1:0] f,
  output logic          cout,
  output logic          ovr
);

  logic [SW-1:0] opx;
  logic [SW-1:0] opy;
  logic [SW:0]   carry;

  // carry vector: bit i is the carry into position i, bit SW the carry out
  function automatic logic [SW:0] ripple(input logic [SW-1:0] x,
                                         input logic [SW-1:0] y,
                                         input logic          ci);
    logic [SW:0] c;
    c[0] = ci;
    for (int i = 0; i < SW; i++) begin
      c[i+1] = (x[i] & y[i]) | ((x[i] ^ y[i]) & c[i]);
    end
    return c;
  endfunction

  // operand steering for the arithmetic codes
  always_comb begin
    opx = a;
    opy = b;
    case (alu_fn_e'(fn))
      FN_B_SUB_A: begin
        opx = b;
        opy = ~a;
      end
      FN_A_SUB_B: begin
        opx = a;
        opy = ~b;
      end
      default: ;
    endcase
  end

  assign carry = ripple(opx, opy, cin);

  always_comb begin
    f    = '0;
    cout = 1'b0;
    ovr  = 1'b0;
    case (alu_fn_e'(fn))
      FN_ZERO: begin
        f    = '0;
        cout = 1'b1;
        ovr  = 1'b1;
      end
      FN_ONES: f = '1;
      FN_XOR:  f = a ^ b;
      FN_OR:   f = a | b;
      FN_AND:  f = a & b;
      default: begin
        f    = opx ^ opy ^ carry[SW-1:0];
        cout = carry[SW];
        ovr  = carry[SW] ^ carry[SW-1];
      end
    endcase
  end

endmodule

// File: rtl/alu_chain.sv
module alu_chain
  import ripple_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic [2:0]       fn,
  output logic [WIDTH-1:0] f,
  output logic             cout,
  output logic             ovf
);

  localparam int NSLICE = WIDTH / SLICE_W;

  logic [NSLICE:0]   link;
  logic [NSLICE-1:0] slice_ovr;

  assign link[0] = cin;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    alu_slice4 #(.SW(SLICE_W)) u_slice (
      .a    (a[k*SLICE_W +: SLICE_W]),
      .b    (b[k*SLICE_W +: SLICE_W]),
      .cin  (link[k]),
      .fn   (fn),
      .f    (f[k*SLICE_W +: SLICE_W]),
      .cout (link[k+1]),
      .ovr  (slice_ovr[k])
    );

    // every slice raises both flags in the zero code
    always_comb begin
      if (fn == 3'(FN_ZERO)) begin
        AST_SLICE_ZERO_FLAGS: assert (slice_ovr[k] && link[k+1]); // R1
      end
    end
  end

  assign cout = link[NSLICE];
  assign ovf  = slice_ovr[NSLICE-1];

endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import ripple_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  input  logic [2:0]       func,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] nxt_result;
  logic             nxt_carry;
  logic             nxt_ovf;

  alu_chain #(.WIDTH(WIDTH)) u_chain (
    .a    (op_a),
    .b    (op_b),
    .cin  (carry_in),
    .fn   (func),
    .f    (nxt_result),
    .cout (nxt_carry),
    .ovf  (nxt_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      result    <= nxt_result;
      carry_out <= nxt_carry;
      ovf       <= nxt_ovf;
    end
  end

  AST_RESET_ZEROES: assert property (@(posedge clk)
    rst |=> (result == '0 && !carry_out && !ovf)); // R8

  AST_ZERO_CODE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(func) == 3'(FN_ZERO))
      |-> (result == '0 && carry_out && ovf)); // R1

  AST_ONES_CODE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(func) == 3'(FN_ONES))
      |-> (result == '1 && !carry_out && !ovf)); // R2

  AST_LOGIC_FLAGS_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(func[2]) && $past(func) != 3'(FN_ONES))
      |-> (!carry_out && !ovf)); // R7

  AST_ADD_OVF_SIGNS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(func) == 3'(FN_ADD) && ovf)
      |-> ($past(op_a[MSB]) == $past(op_b[MSB]) && result[MSB] != $past(op_a[MSB]))); // R6

endmodule

// File: tb/ripple_alu_bench.sv
`timescale 1ns/1ps
module ripple_alu_bench;

  localparam int WW = 16;
  localparam int NW = 4;

  typedef struct {
    string       tag;
    logic [WW-1:0] wres;
    logic        wco;
    logic        wov;
    logic [NW-1:0] nres;
    logic        nco;
    logic        nov;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [WW-1:0] op_a = '0;
  logic [WW-1:0] op_b = '0;
  logic          carry_in = 1'b0;
  logic [2:0]    func = 3'b000;
  logic [WW-1:0] w_res;
  logic          w_co;
  logic          w_ov;
  logic [NW-1:0] n_res;
  logic          n_co;
  logic          n_ov;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  exp_t sb[$];
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  ripple_alu #(.WIDTH(WW)) u_ripple_alu (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .func(func), .result(w_res), .carry_out(w_co), .ovf(w_ov)
  );

  ripple_alu #(.WIDTH(NW)) u_ripple_alu_w4 (
    .clk(clk), .rst(rst), .op_a(op_a[NW-1:0]), .op_b(op_b[NW-1:0]),
    .carry_in(carry_in), .func(func), .result(n_res), .carry_out(n_co), .ovf(n_ov)
  );

  // reference computed from the requirements with plain integer arithmetic
  function automatic void model(input int w, input longint a, input longint b,
                                input bit ci, input logic [2:0] fn,
                                output longint f, output bit co, output bit ov);
    longint m = (longint'(1) << w) - 1;
    longint hm = m >> 1;
    longint x = a & m;
    longint y = b & m;
    longint s;
    bit cmsb;
    co = 1'b0;
    ov = 1'b0;
    case (fn)
      3'b000: begin f = 0; co = 1'b1; ov = 1'b1; end
      3'b111: f = m;
      3'b100: f = x ^ y;
      3'b101: f = x | y;
      3'b110: f = x & y;
      default: begin
        if (fn == 3'b001) begin x = b & m; y = (~a) & m; end
        else if (fn == 3'b010) begin x = a & m; y = (~b) & m; end
        s    = x + y + longint'(ci);
        f    = s & m;
        co   = s[w];
        cmsb = (((x & hm) + (y & hm) + longint'(ci)) >> (w - 1)) & 1;
        ov   = cmsb ^ co;
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] fn);
    case (fn)
      3'b000: return "R1";
      3'b111: return "R2";
      3'b011: return "R3";
      3'b001: return "R4";
      3'b010: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic step_lfsr();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic drive(input logic [WW-1:0] a, input logic [WW-1:0] b,
                       input bit ci, input logic [2:0] fn, input string tag);
    exp_t e;
    longint f;
    bit co, ov;
    @(negedge clk);
    rst = 1'b0;
    op_a = a;
    op_b = b;
    carry_in = ci;
    func = fn;
    e.tag = tag;
    model(WW, longint'(a), longint'(b), ci, fn, f, co, ov);
    e.wres = f[WW-1:0]; e.wco = co; e.wov = ov;
    model(NW, longint'(a[NW-1:0]), longint'(b[NW-1:0]), ci, fn, f, co, ov);
    e.nres = f[NW-1:0]; e.nco = co; e.nov = ov;
    sb.push_back(e);
  endtask

  task automatic pulse_reset();
    exp_t e;
    @(negedge clk);
    rst = 1'b1;
    func = 3'b111;
    e.tag = "R8";
    e.wres = '0; e.wco = 1'b0; e.wov = 1'b0;
    e.nres = '0; e.nco = 1'b0; e.nov = 1'b0;
    sb.push_back(e);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: one expected entry per rising edge that captured a stimulus
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        n_cmp++;
        if (w_res !== e.wres || w_co !== e.wco || w_ov !== e.wov) begin
          n_bad++;
          $display("FAIL %s wide: got res=%h co=%b ov=%b expected res=%h co=%b ov=%b",
                   e.tag, w_res, w_co, w_ov, e.wres, e.wco, e.wov);
        end
        n_cmp++;
        if (n_res !== e.nres || n_co !== e.nco || n_ov !== e.nov) begin
          n_bad++;
          $display("FAIL %s narrow: got res=%h co=%b ov=%b expected res=%h co=%b ov=%b",
                   e.tag, n_res, n_co, n_ov, e.nres, e.nco, e.nov);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung run expected completion");
    report();
  end

  initial begin
    // R8: reset state before any stimulus
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (w_res !== '0 || w_co !== 1'b0 || w_ov !== 1'b0 ||
        n_res !== '0 || n_co !== 1'b0 || n_ov !== 1'b0) begin
      n_bad++;
      $display("FAIL R8 reset: got %h %b %b / %h %b %b expected all zero",
               w_res, w_co, w_ov, n_res, n_co, n_ov);
    end

    // exhaustive nibble sweep over every code and carry (R1..R7, R9 ripple)
    for (int fn = 0; fn < 8; fn++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int a = 0; a < 16; a++) begin
          for (int b = 0; b < 16; b++) begin
            step_lfsr();
            drive({lf[11:0], 4'(a)}, {lf[15:4], 4'(b)}, 1'(ci), 3'(fn), tag_of(3'(fn)));
          end
        end
      end
    end

    // R9: all-ones add corner on both widths
    drive(16'hFFFF, 16'hFFFF, 1'b0, 3'b011, "R9");
    drive(16'hFFFF, 16'hFFFF, 1'b1, 3'b011, "R9");
    // R6: signed overflow at the word boundary
    drive(16'h7FFF, 16'h0001, 1'b0, 3'b011, "R6");
    drive(16'h8000, 16'h0001, 1'b1, 3'b010, "R6");
    drive(16'h0001, 16'h8000, 1'b1, 3'b001, "R6");
    drive(16'h8000, 16'h8000, 1'b0, 3'b011, "R6");
    // R4 / R5: borrow chain across all slices with carry_in low and high
    drive(16'h0000, 16'h0000, 1'b0, 3'b001, "R4");
    drive(16'h0000, 16'h0000, 1'b1, 3'b010, "R5");
    drive(16'h1234, 16'h1000, 1'b1, 3'b001, "R4");
    drive(16'h1234, 16'h1000, 1'b0, 3'b010, "R5");

    // R8: reset in mid stream, then operation resumes
    drive(16'hFFFF, 16'h0001, 1'b0, 3'b011, "R3");
    pulse_reset();
    drive(16'h00FF, 16'h0F0F, 1'b1, 3'b101, "R7");

    // wide pseudo-random arithmetic (R3, R4, R5, R6 across the ripple)
    for (int n = 0; n < 2000; n++) begin
      logic [WW-1:0] ra;
      step_lfsr();
      ra = lf;
      step_lfsr();
      drive(ra, lf, lf[3], 3'(1 + (n % 3)), (n % 3 == 0) ? "R4" : (n % 3 == 1) ? "R5" : "R3");
    end

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R8 drain: got %0d pending expected 0", sb.size());
    end
    report();
  end

endmodule